// File: doc/BRIEF.md
# Microcontroller Reset Sequencer

This block turns reset requests from an external open-drain reset pad and from a supply-voltage monitor into one internal system reset with a fixed release order. A low level on the pad is captured without a clock, so the core goes into reset even while its clock is stopped. Once a pad request is recognised, the block drives the pad low itself for a minimum number of cycles. A short pulse from outside therefore comes back out stretched to a clean width. A long pulse gets no extra length added.

Each reset passes through three phases. In the active phase, the reset cause is still present or the pad is still being driven. In the delay phase, the block counts a selectable 256 or 4096 cycles. The vector-fetch phase is a single cycle that pulses a strobe, and the core is released after it. The supply monitor gives two digital levels: supply under the lower threshold, and supply under the upper threshold. Both are filtered against spikes. The lower one raises a low-voltage condition. That condition clears only when the supply is also back over the upper threshold. While the condition holds, the pad is driven low. A new request in the delay or fetch phase starts the sequence again. A cause register records which source started the last reset.

Top module: `rstseq_top`

## Requirements
- R1: A low level on `pin_n_i` asserts `sys_rst_o` at once, with no clock edge needed. A pulse that arrives while the clock is stopped is held until the clock runs, and it then starts a full sequence.
- R2: A recognised pad request drives `pin_drv_n_o` low for exactly PIN_MIN_CYC cycles, starting after the first clock edge that sees the pad low. This holds for pulses of any length, including pulses that no clock edge saw. While `pin_drv_n_o` is low, `sys_rst_o` is high.
- R3: Let the pad be held low from outside across L clock edges, counted from the first edge that sees it low. `vec_fetch_o` is then high just after edge max(L, PIN_MIN_CYC+1)+D+3, where D is the delay length. So a pulse longer than the stretch adds no delay beyond its own length.
- R4: `sys_rst_o` stays high through the delay phase. `vec_fetch_o` is high for exactly one cycle, while `sys_rst_o` is still high. `sys_rst_o` falls in the next cycle and falls at no other time.
- R5: The delay phase lasts DLY_SHORT cycles (256) when `dly_long_i` is 0 and DLY_LONG cycles (4096) when it is 1. The input is sampled when the active phase ends.
- R6: A new pad request during the delay phase or during the fetch cycle sends the sequence back to the active phase. No strobe is given for the interrupted sequence.
- R7: While `rst_i` is high, the block is in the power-on state: `sys_rst_o` high, pad driven low, `vec_fetch_o` low, `cause_o` = 2.
- R8: When `vdd_under_lo_i` rises and stays high, `sys_rst_o` and the pad drive turn on just after edge FILT_CYC+3, not before. The pad stays driven for as long as the condition holds. `cause_o` becomes 3.
- R9: The low-voltage condition, whether from power-on or from a supply drop, does not clear while `vdd_under_hi_i` is high. After both supply inputs are low, `vec_fetch_o` is high just after edge FILT_CYC+6+D, counted from the edge at which `vdd_under_hi_i` is first seen low.
- R10: A pulse on `vdd_under_lo_i` shorter than FILT_CYC cycles has no effect at the outputs. A pulse of FILT_CYC cycles or more starts a voltage-drop reset.
- R11: `cause_o` is 1 after a pad reset, 2 after power-on and 3 after a supply drop. It changes only while `sys_rst_o` is high. A pad pulse during a low-voltage condition leaves it at 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock; may be stopped |
| rst_i | input | 1 | Synchronous active-high power-up initialisation |
| pin_n_i | input | 1 | Level read back from the reset pad, active low |
| pin_drv_n_o | output | 1 | Pad pull-down enable, active low |
| vdd_under_lo_i | input | 1 | Supply is below the lower threshold |
| vdd_under_hi_i | input | 1 | Supply is below the upper threshold |
| dly_long_i | input | 1 | 1 selects the long internal delay |
| sys_rst_o | output | 1 | Internal system reset, active high |
| vec_fetch_o | output | 1 | One-cycle strobe that releases the core to fetch its reset vector |
| cause_o | output | 2 | Last reset source: 1 pad, 2 power-on, 3 supply drop |

## Verification
Pad pulses from one to twelve cycles are swept across the stretch boundary. The drive width shows whether stretching happens. The strobe position shows whether long pulses add delay. A pulse given while the clock is stopped shows that capture is asynchronous. A second request in the delay phase, and another in the fetch cycle, show whether the sequence restarts. Supply-pulse widths swept around the filter length separate spikes from real drops. Clearing the two supply levels in turn shows that release waits for the upper threshold.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {
    PH_ACTIVE = 2'd0,
    PH_DELAY  = 2'd1,
    PH_FETCH  = 2'd2,
    PH_RUN    = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_PAD   = 2'd1,
    CAUSE_POWER = 2'd2,
    CAUSE_DROP  = 2'd3
  } cause_e;
endpackage

// File: rtl/rstseq_pad_sync.sv
// Asynchronous capture of a low pad level with clocked two-stage release.
module rstseq_pad_sync (
  input  logic clk_i,
  input  logic rst_i,
  input  logic pin_n_i,
  output logic req_o
);
  logic stage_q;

  always_ff @(posedge clk_i or negedge pin_n_i) begin
    if (!pin_n_i) begin
      stage_q <= 1'b1;
      req_o   <= 1'b1;
    end else if (rst_i) begin
      stage_q <= 1'b0;
      req_o   <= 1'b0;
    end else begin
      stage_q <= 1'b0;
      req_o   <= stage_q;
    end
  end
endmodule

// File: rtl/rstseq_filter.sv
// Two-flop synchroniser followed by a stability filter of LEN cycles.
module rstseq_filter #(
  parameter int LEN = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [1:0] sync_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) sync_q <= 2'b11;
    else       sync_q <= {sync_q[0], raw_i};
  end

  generate
    if (LEN <= 1) begin : g_direct
      always_ff @(posedge clk_i) begin
        if (rst_i) filt_o <= 1'b1;
        else       filt_o <= sync_q[1];
      end
    end else begin : g_count
      logic [CW-1:0] run_q;
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          filt_o <= 1'b1;
          run_q  <= '0;
        end else if (sync_q[1] == filt_o) begin
          run_q  <= '0;
        end else if (run_q == CW'(LEN - 1)) begin
          filt_o <= sync_q[1];
          run_q  <= '0;
        end else begin
          run_q  <= run_q + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/rstseq_drive.sv
// Minimum-width pad pull-down timer, retriggerable.
module rstseq_drive #(
  parameter int WIDTH_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(WIDTH_CYC + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || start_i)   left_q <= CW'(WIDTH_CYC);
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign busy_o = (left_q != '0);
endmodule

// File: rtl/rstseq_fsm.sv
// Phase sequencer: active, delay, one-cycle fetch, run.
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int DLY_SHORT = 256,
  parameter int DLY_LONG  = 4096
) (
  input  logic   clk_i,
  input  logic   rst_i,
  input  logic   hold_i,
  input  logic   dly_long_i,
  output phase_e phase_o
);
  localparam int DMAX = (DLY_LONG > DLY_SHORT) ? DLY_LONG : DLY_SHORT;
  localparam int CW   = (DMAX > 1) ? $clog2(DMAX) : 1;

  logic [CW-1:0] cnt_q;
  logic          long_q;
  logic [CW-1:0] last_cnt;

  assign last_cnt = long_q ? CW'(DLY_LONG - 1) : CW'(DLY_SHORT - 1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_o <= PH_ACTIVE;
      cnt_q   <= '0;
      long_q  <= 1'b0;
    end else if (hold_i) begin
      phase_o <= PH_ACTIVE;
      cnt_q   <= '0;
    end else begin
      case (phase_o)
        PH_ACTIVE: begin
          phase_o <= PH_DELAY;
          cnt_q   <= '0;
          long_q  <= dly_long_i;
        end
        PH_DELAY: begin
          if (cnt_q == last_cnt) phase_o <= PH_FETCH;
          else                   cnt_q   <= cnt_q + 1'b1;
        end
        PH_FETCH: phase_o <= PH_RUN;
        default:  phase_o <= PH_RUN;
      endcase
    end
  end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int PIN_MIN_CYC = 8,
  parameter int FILT_CYC    = 4,
  parameter int DLY_SHORT   = 256,
  parameter int DLY_LONG    = 4096
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       pin_n_i,
  output logic       pin_drv_n_o,
  input  logic       vdd_under_lo_i,
  input  logic       vdd_under_hi_i,
  input  logic       dly_long_i,
  output logic       sys_rst_o,
  output logic       vec_fetch_o,
  output logic [1:0] cause_o
);
  localparam int NSUP = 2;

  logic            pad_req, pad_req_q;
  logic [NSUP-1:0] sup_raw, sup_filt;
  logic            lv_q, lv_rise, pad_rec, drv_busy, hold;
  cause_e          cause_q;
  phase_e          phase;

  rstseq_pad_sync u_pad (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .pin_n_i(pin_n_i),
    .req_o  (pad_req)
  );

  assign sup_raw = {vdd_under_hi_i, vdd_under_lo_i};

  generate
    for (genvar g = 0; g < NSUP; g++) begin : g_sup
      rstseq_filter #(.LEN(FILT_CYC)) u_filt (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .raw_i (sup_raw[g]),
        .filt_o(sup_filt[g])
      );
    end
  endgenerate

  // A pad edge counts only when the block is not pulling the pad itself.
  assign lv_rise = sup_filt[0] & ~lv_q;
  assign pad_rec = pad_req & ~pad_req_q & ~lv_q & ~drv_busy;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pad_req_q <= 1'b1;
      lv_q      <= 1'b1;
      cause_q   <= CAUSE_POWER;
    end else begin
      pad_req_q <= pad_req;
      if (sup_filt[0])       lv_q <= 1'b1;
      else if (!sup_filt[1]) lv_q <= 1'b0;
      if (lv_rise)           cause_q <= CAUSE_DROP;
      else if (pad_rec)      cause_q <= CAUSE_PAD;
    end
  end

  rstseq_drive #(.WIDTH_CYC(PIN_MIN_CYC)) u_drive (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .start_i(pad_rec | lv_rise),
    .busy_o (drv_busy)
  );

  assign hold = pad_req | drv_busy | lv_q;

  rstseq_fsm #(.DLY_SHORT(DLY_SHORT), .DLY_LONG(DLY_LONG)) u_fsm (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .hold_i    (hold),
    .dly_long_i(dly_long_i),
    .phase_o   (phase)
  );

  assign pin_drv_n_o = ~(drv_busy | lv_q);
  assign sys_rst_o   = pad_req | (phase != PH_RUN);
  assign vec_fetch_o = (phase == PH_FETCH);
  assign cause_o     = cause_q;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
  parameter int PIN_MIN_CYC = 8
) (
  input logic       clk_i,
  input logic       rst_i,
  input logic       pin_drv_n_o,
  input logic       sys_rst_o,
  input logic       vec_fetch_o,
  input logic [1:0] cause_o
);
  localparam int CW = $clog2(PIN_MIN_CYC + 2);

  logic [CW-1:0] low_run_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)                              low_run_q <= CW'(PIN_MIN_CYC);
    else if (pin_drv_n_o)                   low_run_q <= '0;
    else if (low_run_q < CW'(PIN_MIN_CYC))  low_run_q <= low_run_q + 1'b1;
  end

  // R4
  fetch_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    vec_fetch_o |=> !vec_fetch_o);

  // R4
  fetch_in_reset_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    vec_fetch_o |-> sys_rst_o);

  // R4
  release_after_fetch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(sys_rst_o) |-> $past(vec_fetch_o));

  // R2
  drive_in_reset_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !pin_drv_n_o |-> sys_rst_o);

  // R2
  drive_min_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(pin_drv_n_o) |-> (low_run_q >= CW'(PIN_MIN_CYC)));

  // R11
  cause_in_reset_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(cause_o) |-> sys_rst_o);
endmodule

bind rstseq_top rstseq_chk #(.PIN_MIN_CYC(PIN_MIN_CYC)) chk_i (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .pin_drv_n_o(pin_drv_n_o),
  .sys_rst_o  (sys_rst_o),
  .vec_fetch_o(vec_fetch_o),
  .cause_o    (cause_o)
);

// File: tb/rstseq_top_tb_top.sv
`timescale 1ns/1ps
module rstseq_top_tb_top;
  localparam int P  = 8;
  localparam int F  = 4;
  localparam int DS = 256;
  localparam int DL = 4096;

  logic clk_free = 1'b0;
  logic clk_en   = 1'b1;
  logic clk;
  logic rst = 1'b1;
  logic ext_low = 1'b0;
  logic vlo = 1'b1, vhi = 1'b1, dly_long = 1'b0;
  logic pin_n, pin_drv_n, sys_rst, vfetch;
  logic [1:0] cause;
  int total = 0, fails = 0;

  always #5 clk_free = ~clk_free;
  assign clk   = clk_free & clk_en;
  assign pin_n = ~(ext_low | ~pin_drv_n);

  rstseq_top #(.PIN_MIN_CYC(P), .FILT_CYC(F), .DLY_SHORT(DS), .DLY_LONG(DL)) dut_i (
    .clk_i(clk), .rst_i(rst), .pin_n_i(pin_n), .pin_drv_n_o(pin_drv_n),
    .vdd_under_lo_i(vlo), .vdd_under_hi_i(vhi), .dly_long_i(dly_long),
    .sys_rst_o(sys_rst), .vec_fetch_o(vfetch), .cause_o(cause)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Called at a negedge; pad held low from outside for L edges.
  task automatic pad_seq(int L, output int kf, output int drv);
    kf = 0; drv = 0;
    if (L > 0) begin
      ext_low = 1'b1;
      #1 chk("R1 async assert", sys_rst, 1);
    end
    for (int k = 1; k <= 6000; k++) begin
      @(negedge clk_free);
      if (!pin_drv_n) drv++;
      if (k == L) ext_low = 1'b0;
      if (vfetch) begin kf = k; break; end
    end
  endtask

  task automatic wait_fetch(output int kf);
    kf = 0;
    for (int k = 1; k <= 6000; k++) begin
      @(negedge clk_free);
      if (vfetch) begin kf = k; break; end
    end
  endtask

  task automatic post_release(string tag);
    @(negedge clk_free);
    chk({tag, " released"}, sys_rst, 0);
    chk({tag, " strobe single"}, vfetch, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_free);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int kf, drv, saw, cnt;
    // R7 power-on state
    repeat (4) @(negedge clk_free);
    chk("R7 sys_rst", sys_rst, 1);
    chk("R7 pad drive", pin_drv_n, 0);
    chk("R7 strobe", vfetch, 0);
    chk("R7 cause", cause, 2);
    rst = 1'b0;
    vlo = 1'b0;
    // R9 hysteresis: upper level still low
    saw = 0;
    repeat (30) begin @(negedge clk_free); if (!sys_rst || pin_drv_n) saw++; end
    chk("R9 held by upper level", saw, 0);
    vhi = 1'b0;
    wait_fetch(kf);
    chk("R9 power-on release edge", kf, F + 6 + DS);
    post_release("R4 power-on");
    chk("R11 cause power-on", cause, 2);

    // R2 R3 sweep of pad pulse lengths
    for (int L = 1; L <= 12; L++) begin
      repeat (3) @(negedge clk_free);
      pad_seq(L, kf, drv);
      chk($sformatf("R2 drive width L=%0d", L), drv, P);
      chk($sformatf("R3 fetch edge L=%0d", L), kf, ((L > P + 1) ? L : P + 1) + DS + 3);
      post_release("R4 pad");
      chk("R11 cause pad", cause, 1);
    end

    // R5 long delay
    dly_long = 1'b1;
    pad_seq(3, kf, drv);
    chk("R5 long delay", kf, P + 1 + DL + 3);
    post_release("R5");
    dly_long = 1'b0;

    // R6 restart during delay
    ext_low = 1'b1;
    saw = 0;
    for (int k = 1; k <= 100; k++) begin
      @(negedge clk_free);
      if (k == 2) ext_low = 1'b0;
      if (vfetch || !sys_rst) saw++;
    end
    chk("R6 no early release", saw, 0);
    pad_seq(2, kf, drv);
    chk("R6 restart in delay", kf, P + 1 + DS + 3);
    // R6 restart during fetch cycle
    pad_seq(2, kf, drv);
    chk("R6 restart in fetch", kf, P + 1 + DS + 3);
    post_release("R6");

    // R1 capture with stopped clock
    @(negedge clk_free);
    clk_en = 1'b0;
    #20 ext_low = 1'b1;
    #10 chk("R1 stopped clock assert", sys_rst, 1);
    #10 ext_low = 1'b0;
    #10 chk("R1 stopped clock held", sys_rst, 1);
    @(negedge clk_free);
    clk_en = 1'b1;
    pad_seq(0, kf, drv);
    chk("R2 stretch of unclocked pulse", drv, P);
    chk("R1 sequence after stopped clock", kf, P + 1 + DS + 3);
    post_release("R1");

    // R8 supply drop
    @(negedge clk_free);
    vlo = 1'b1; vhi = 1'b1;
    for (int k = 1; k <= F + 3; k++) begin
      @(negedge clk_free);
      if (k == F + 2) chk("R8 not before filter", sys_rst, 0);
      if (k == F + 3) begin
        chk("R8 reset on drop", sys_rst, 1);
        chk("R8 pad driven", pin_drv_n, 0);
        chk("R8 cause", cause, 3);
      end
    end
    ext_low = 1'b1;
    repeat (5) @(negedge clk_free);
    ext_low = 1'b0;
    repeat (40) @(negedge clk_free);
    chk("R11 pad ignored in low voltage", cause, 3);
    chk("R8 pad still driven", pin_drv_n, 0);
    vlo = 1'b0;
    saw = 0;
    repeat (30) begin @(negedge clk_free); if (!sys_rst || vfetch) saw++; end
    chk("R9 drop held by upper level", saw, 0);
    vhi = 1'b0;
    wait_fetch(kf);
    chk("R9 drop release edge", kf, F + 6 + DS);
    post_release("R8");
    chk("R11 cause drop kept", cause, 3);

    // R10 spike filter sweep, starting from a pad cause
    pad_seq(2, kf, drv);
    post_release("R10 prep");
    for (int w = 1; w <= F + 1; w++) begin
      repeat (3) @(negedge clk_free);
      vlo = 1'b1;
      saw = 0; cnt = 0;
      for (int k = 1; k <= 2 * F + 10; k++) begin
        @(negedge clk_free);
        if (k == w) vlo = 1'b0;
        if (sys_rst) saw = 1;
      end
      chk($sformatf("R10 spike width %0d", w), saw, (w >= F) ? 1 : 0);
      if (w >= F) begin
        wait_fetch(kf);
        chk("R10 accepted drop completes", (kf > 0) ? 1 : 0, 1);
        post_release("R10");
        chk("R10 cause drop", cause, 3);
      end else begin
        chk("R10 cause untouched", cause, 1);
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule